// File: doc/BRIEF.md
# Adder-Based Constant Coefficient Multiplier

This block multiplies a signed input word by a positive integer constant that is fixed at elaboration. No multiply operator is used. The product is built from shifted, sign-extended copies of the input that are combined by addition and subtraction. Elaboration-time functions recode the constant into canonical signed digits. The digits select which shifted terms are added and which are subtracted.

Two shift-add structures are available. The direct structure realises the whole constant as one signed-digit network. The factored structure splits the constant into two factors and realises each factor as its own signed-digit network. The first network's result feeds the second. An automatic setting picks the structure that needs fewer adders. A fallback setting uses an ordinary multiply. The output can be registered or left combinational.

Top module: `cmul_const`

## Requirements
- R1: For every input value, `dout` equals the low OUT_W bits of the two's-complement product of `din` and COEF, read as a signed number.
- R2: The constant is recoded into digits from {-1, 0, +1} with no two adjacent nonzero digits. The adder cost of a network is its number of nonzero digits minus one. For 231 the recoding is +2^8 - 2^5 + 2^3 - 2^0, which costs 3 adders.
- R3: In the factored structure, the input goes through the first factor's network, and that network's result is the input of the second factor's network. The split is the one with the smallest summed adder cost. The larger factor is placed first. For 231 the factors are 33 then 7, at a total cost of 2 adders.
- R4: The structure selector is encoded as automatic=0, direct=1, factored=2, multiply=3. The automatic setting resolves to factored only when factored costs strictly fewer adders than direct, and to direct otherwise:
  - 231 resolves to factored (3 adders direct against 2 factored).
  - 45 resolves to factored (3 against 2, with factors 15 then 3).
  - 21 resolves to direct (a tie at 2 against 2).
  - 7 resolves to direct (it has no factor pair).
- R5: The multiply setting gives the same result as the shift-add settings for every input.
- R6: With REG_OUT=1, `dout` shows the product of the `din` sampled at the previous rising clock edge. An active-low `rst_n` clears `dout` to zero asynchronously.
- R7: With REG_OUT=0, `dout` follows `din` in the same cycle, with no clock edge needed.
- R8: The full accumulator width is IN_W + ceil(log2(COEF+1)) + 1. This gives 21 bits for a 12-bit input and the constant 231. OUT_W may not exceed this width, and `dout` takes its low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| din | input | IN_W | Signed multiplicand |
| dout | output | OUT_W | Signed product, truncated to OUT_W bits |

## Verification
On every clock cycle, assertions check three things:
- The full-width accumulator against an arithmetic product.
- In the factored structure, each factor stage's result against its own factor times that stage's input.
- The registered or combinational output timing, together with the zero value after reset.

Only the bench's scenarios show the rest. An exhaustive sweep of all 4096 twelve-bit inputs runs through several constants and structures. The bench also checks the digit recoding, the chosen factor split and the automatic selection, including the tie case. Finally, it checks the asynchronous clear during a running sweep.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

   typedef enum logic [1:0] {
      ARCH_AUTO = 2'd0,
      ARCH_CSD  = 2'd1,
      ARCH_FCSD = 2'd2,
      ARCH_MULT = 2'd3
   } arch_e;

   localparam int DIG_MAX = 32;

   typedef struct packed {
      logic [DIG_MAX-1:0] pos;
      logic [DIG_MAX-1:0] neg;
   } csd_t;

   // Non-adjacent signed-digit recoding of a positive constant.
   function automatic csd_t csd_digits(input int unsigned value);
      csd_t r;
      int unsigned rem;
      r   = '0;
      rem = value;
      for (int i = 0; i < DIG_MAX; i++) begin
         if (rem[0]) begin
            if (rem[1]) begin
               r.neg[i] = 1'b1;
               rem      = rem + 1;
            end else begin
               r.pos[i] = 1'b1;
               rem      = rem - 1;
            end
         end
         rem = rem >> 1;
      end
      return r;
   endfunction

   function automatic int csd_adders(input int unsigned value);
      csd_t d;
      int   n;
      d = csd_digits(value);
      n = 0;
      for (int i = 0; i < DIG_MAX; i++) begin
         if (d.pos[i] || d.neg[i]) n++;
      end
      return (n == 0) ? 0 : n - 1;
   endfunction

   // Smaller factor of the cheapest two-factor split; 0 when none exists.
   function automatic int unsigned fcsd_second(input int unsigned value);
      int          best;
      int          cost;
      int unsigned sel;
      best = 32'h3fff_ffff;
      sel  = 0;
      for (int unsigned f = 2; f * f <= value; f++) begin
         if (value % f == 0) begin
            cost = csd_adders(value / f) + csd_adders(f);
            if (cost < best) begin
               best = cost;
               sel  = f;
            end
         end
      end
      return sel;
   endfunction

   function automatic int fcsd_cost(input int unsigned value);
      int unsigned f;
      f = fcsd_second(value);
      return (f == 0) ? 0 : csd_adders(value / f) + csd_adders(f);
   endfunction

   function automatic arch_e arch_resolve(input arch_e req, input int unsigned value);
      if (req != ARCH_AUTO) return req;
      if (fcsd_second(value) != 0 && fcsd_cost(value) < csd_adders(value))
         return ARCH_FCSD;
      return ARCH_CSD;
   endfunction

   function automatic int acc_width(input int in_w, input int unsigned value);
      return in_w + $clog2(value + 1) + 1;
   endfunction

endpackage

// File: rtl/cmul_shift_add.sv
module cmul_shift_add #(
   parameter int          W_IN  = 12,
   parameter int          W_OUT = 21,
   parameter int unsigned COEF  = 231
) (
   input  logic signed [W_IN-1:0]  x,
   output logic signed [W_OUT-1:0] y
);
   import cmul_pkg::*;

   localparam csd_t DIG = csd_digits(COEF);
   localparam int   NB  = $clog2(COEF + 1) + 1;

   if (W_OUT < W_IN) begin : g_bad_width
      $error("cmul_shift_add: W_OUT must not be below W_IN");
   end
   if (NB > DIG_MAX) begin : g_bad_coef
      $error("cmul_shift_add: constant too wide for digit recoding");
   end

   logic signed [W_OUT-1:0] xe;
   assign xe = W_OUT'(x);

   for (genvar i = 0; i < NB; i++) begin : g_dig
      logic signed [W_OUT-1:0] prev;
      logic signed [W_OUT-1:0] sum;
      if (i == 0) begin : g_first
         assign prev = '0;
      end else begin : g_next
         assign prev = g_dig[i-1].sum;
      end
      if (DIG.pos[i]) begin : g_add
         assign sum = prev + (xe <<< i);
      end else if (DIG.neg[i]) begin : g_sub
         assign sum = prev - (xe <<< i);
      end else begin : g_pass
         assign sum = prev;
      end
   end

   assign y = g_dig[NB-1].sum;

endmodule

// File: rtl/cmul_mult.sv
module cmul_mult #(
   parameter int          W_IN  = 12,
   parameter int          W_OUT = 21,
   parameter int unsigned COEF  = 231
) (
   input  logic signed [W_IN-1:0]  x,
   output logic signed [W_OUT-1:0] y
);
   logic signed [W_OUT-1:0] xe;
   logic signed [W_OUT-1:0] k;

   assign xe = W_OUT'(x);
   assign k  = W_OUT'(COEF);
   assign y  = xe * k;

endmodule

// File: rtl/cmul_out_reg.sv
module cmul_out_reg #(
   parameter int W   = 20,
   parameter bit REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] d,
   output logic signed [W-1:0] q
);
   if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_comb
      assign q = d;
   end

endmodule

// File: rtl/cmul_const.sv
module cmul_const #(
   parameter int                   IN_W    = 12,
   parameter int                   OUT_W   = 20,
   parameter int unsigned          COEF    = 231,
   parameter cmul_pkg::arch_e      ARCH    = cmul_pkg::ARCH_AUTO,
   parameter bit                   REG_OUT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   import cmul_pkg::*;

   localparam int          ACC_W = acc_width(IN_W, COEF);
   localparam arch_e       SEL   = arch_resolve(ARCH, COEF);
   localparam int unsigned F2    = fcsd_second(COEF);
   localparam int unsigned F1    = (F2 == 0) ? COEF : COEF / F2;
   localparam int          S1_W  = acc_width(IN_W, F1);

   if (IN_W < 2) begin : g_chk_in
      $error("cmul_const: IN_W must be at least 2");
   end
   if (COEF < 1 || COEF >= (1 << 28)) begin : g_chk_coef
      $error("cmul_const: COEF out of supported range");
   end
   if (OUT_W < 1 || OUT_W > ACC_W) begin : g_chk_out
      $error("cmul_const: OUT_W must lie in 1..accumulator width");
   end
   if (SEL == ARCH_FCSD && F2 == 0) begin : g_chk_split
      $error("cmul_const: factored form requested for a constant with no split");
   end

   logic signed [ACC_W-1:0] acc;
   logic signed [OUT_W-1:0] dout_d;

   if (SEL == ARCH_MULT) begin : g_mult
      cmul_mult #(.W_IN(IN_W), .W_OUT(ACC_W), .COEF(COEF)) u_mult (
         .x (din),
         .y (acc)
      );
   end else if (SEL == ARCH_FCSD) begin : g_fcsd
      logic signed [S1_W-1:0]  s1;
      logic signed [S1_W-1:0]  s1_ref;
      logic signed [ACC_W-1:0] s2_ref;

      cmul_shift_add #(.W_IN(IN_W), .W_OUT(S1_W), .COEF(F1)) u_stage1 (
         .x (din),
         .y (s1)
      );
      cmul_shift_add #(.W_IN(S1_W), .W_OUT(ACC_W), .COEF(F2)) u_stage2 (
         .x (s1),
         .y (acc)
      );

      assign s1_ref = S1_W'(din) * S1_W'(F1);
      assign s2_ref = ACC_W'(s1) * ACC_W'(F2);

      // R3: first factor stage result
      p_stage1_r3: assert property (@(posedge clk) disable iff (!rst_n)
         s1 == s1_ref);
      // R3: second stage consumes the first stage's result
      p_stage2_r3: assert property (@(posedge clk) disable iff (!rst_n)
         acc == s2_ref);
   end else begin : g_csd
      cmul_shift_add #(.W_IN(IN_W), .W_OUT(ACC_W), .COEF(COEF)) u_net (
         .x (din),
         .y (acc)
      );
   end

   assign dout_d = acc[OUT_W-1:0];

   cmul_out_reg #(.W(OUT_W), .REG(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dout_d),
      .q     (dout)
   );

   // Arithmetic references used only by the assertions below.
   logic signed [ACC_W-1:0] ref_full;
   logic signed [OUT_W-1:0] ref_now;
   assign ref_full = ACC_W'(din) * ACC_W'(COEF);
   assign ref_now  = OUT_W'(ref_full);

   // R8: full accumulator holds the exact product
   p_full_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc == ref_full);

   if (REG_OUT) begin : g_chk_reg
      // R6: output cleared on leaving reset
      p_reset_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> dout == '0);
      // R6 / R1: one-cycle latency product
      p_reg_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> dout == $past(ref_now));
   end else begin : g_chk_comb
      // R7 / R1: same-cycle product
      p_comb_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
         dout == ref_now);
   end

endmodule

// File: tb/cmul_const_tb.sv
`timescale 1ns/1ps
module cmul_const_tb;
   import cmul_pkg::*;

   logic               clk = 1'b0;
   logic               rst_n;
   logic signed [11:0] din;
   logic signed [19:0] d_auto, d_csd, d_mul;
   logic signed [17:0] d_tie;
   logic signed [18:0] d_f45;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   cmul_const #(.IN_W(12), .OUT_W(20), .COEF(231), .ARCH(ARCH_AUTO), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .din(din), .dout(d_auto));
   cmul_const #(.IN_W(12), .OUT_W(20), .COEF(231), .ARCH(ARCH_CSD), .REG_OUT(1'b0)) u_dut_csd (
      .clk(clk), .rst_n(rst_n), .din(din), .dout(d_csd));
   cmul_const #(.IN_W(12), .OUT_W(20), .COEF(231), .ARCH(ARCH_MULT), .REG_OUT(1'b0)) u_dut_mul (
      .clk(clk), .rst_n(rst_n), .din(din), .dout(d_mul));
   cmul_const #(.IN_W(12), .OUT_W(18), .COEF(21), .ARCH(ARCH_AUTO), .REG_OUT(1'b0)) u_dut_tie (
      .clk(clk), .rst_n(rst_n), .din(din), .dout(d_tie));
   cmul_const #(.IN_W(12), .OUT_W(19), .COEF(45), .ARCH(ARCH_FCSD), .REG_OUT(1'b0)) u_dut_f45 (
      .clk(clk), .rst_n(rst_n), .din(din), .dout(d_f45));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint trunc(input longint p, input int w);
      return (p <<< (64 - w)) >>> (64 - w);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // Recoding, factor split, selection and width checks.
   task automatic check_pkg();
      csd_t d;
      longint xh, x3, xc;
      d = csd_digits(231);
      chk(d.pos == 32'd264, "R2 pos digits 231", longint'(d.pos), 264);
      chk(d.neg == 32'd33,  "R2 neg digits 231", longint'(d.neg), 33);
      chk(csd_adders(231) == 3, "R2 adders 231", csd_adders(231), 3);
      for (int c = 1; c <= 300; c++) begin
         d  = csd_digits(c);
         xh = c >> 1;
         x3 = c + xh;
         xc = xh ^ x3;
         chk(longint'(d.pos) == (x3 & xc) && longint'(d.neg) == (xh & xc),
             "R2 recoding", longint'(d.pos), x3 & xc);
         chk(((d.pos | d.neg) & ((d.pos | d.neg) >> 1)) == '0,
             "R2 no adjacent digits", longint'(d.pos | d.neg), 0);
      end
      chk(fcsd_second(231) == 7, "R3 second factor 231", fcsd_second(231), 7);
      chk(fcsd_cost(231) == 2,   "R3 factored cost 231", fcsd_cost(231), 2);
      chk(fcsd_second(45) == 3,  "R3 second factor 45", fcsd_second(45), 3);
      chk(arch_resolve(ARCH_AUTO, 231) == ARCH_FCSD, "R4 auto 231",
          arch_resolve(ARCH_AUTO, 231), 2);
      chk(arch_resolve(ARCH_AUTO, 45) == ARCH_FCSD, "R4 auto 45",
          arch_resolve(ARCH_AUTO, 45), 2);
      chk(arch_resolve(ARCH_AUTO, 21) == ARCH_CSD, "R4 tie 21",
          arch_resolve(ARCH_AUTO, 21), 1);
      chk(arch_resolve(ARCH_AUTO, 7) == ARCH_CSD, "R4 no split 7",
          arch_resolve(ARCH_AUTO, 7), 1);
      chk(arch_resolve(ARCH_MULT, 231) == ARCH_MULT, "R5 forced multiply",
          arch_resolve(ARCH_MULT, 231), 3);
      chk(acc_width(12, 231) == 21, "R8 accumulator width", acc_width(12, 231), 21);
   endtask

   initial begin
      longint prev;
      rst_n = 1'b0;
      din   = '0;
      repeat (3) @(negedge clk);
      din = 12'sd5;
      @(negedge clk);
      #1;
      chk(d_auto == '0, "R6 held in reset", d_auto, 0);
      check_pkg();
      prev  = 5;
      rst_n = 1'b1;
      for (int v = -2048; v < 2048; v++) begin
         @(negedge clk);
         chk(longint'(d_auto) == trunc(prev * 231, 20), "R1 R6 registered product",
             d_auto, trunc(prev * 231, 20));
         din = 12'(v);
         #1;
         chk(longint'(d_csd) == trunc(longint'(v) * 231, 20), "R1 R7 direct form",
             d_csd, trunc(longint'(v) * 231, 20));
         chk(longint'(d_mul) == trunc(longint'(v) * 231, 20), "R5 multiply form",
             d_mul, trunc(longint'(v) * 231, 20));
         chk(longint'(d_tie) == trunc(longint'(v) * 21, 18), "R4 tie constant 21",
             d_tie, trunc(longint'(v) * 21, 18));
         chk(longint'(d_f45) == trunc(longint'(v) * 45, 19), "R3 factored 45",
             d_f45, trunc(longint'(v) * 45, 19));
         prev = v;
      end
      @(negedge clk);
      chk(longint'(d_auto) == trunc(prev * 231, 20), "R6 last registered product",
          d_auto, trunc(prev * 231, 20));
      din = -12'sd1;
      @(negedge clk);
      chk(longint'(d_auto) == -231, "R1 minus one", d_auto, -231);
      rst_n = 1'b0;
      #1;
      chk(d_auto == '0, "R6 asynchronous clear", d_auto, 0);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule